// File: doc/BRIEF.md
# Control Endpoint Buffer Status Tracker

This block keeps the buffer status flags of one bidirectional control endpoint. The transmit (IN) side has one buffer that firmware arms with a validate command. The serial interface engine reports the buffer as sent, which frees it. The receive (OUT) side records whether a packet is held and whether that packet is an unread SETUP. It also records whether a SETUP arrived on top of a packet that firmware had not yet released. Firmware releases the OUT buffer with a clear command.

The block enforces the control-endpoint handshake rule. An IN buffer cannot be armed while the OUT side holds an overwritten packet or an unread SETUP. Any newly arriving SETUP cancels an IN buffer that was already armed. A refused validate command produces a one-cycle pulse.

All commands and events are single-cycle pulses in one clock domain. Every flag is a register, so each output reflects the pulses of the previous clock edge.

Top module: `ctl_ep_bufstat`

## Requirements
- R1: A synchronous active-high `rst` clears `in_full`, `out_full`, `out_ovwr`, `setup_pend` and `val_rej` to 0 at the next clock edge.
- R2: A `val_cmd` pulse is accepted when `out_ovwr`, `setup_pend` and `ev_setup` are all 0. An accepted `val_cmd` makes `in_full` 1 after the clock edge.
- R3: An `ev_sent` pulse without `val_cmd` or `ev_setup` makes `in_full` 0. When `ev_sent` and an accepted `val_cmd` arrive in the same cycle, `in_full` ends the cycle at 1.
- R4: While `out_ovwr` is 1, a `val_cmd` pulse leaves `in_full` unchanged.
- R5: While `setup_pend` is 1, a `val_cmd` pulse leaves `in_full` unchanged. The registered flag values are used, so a `clr_cmd` in the same cycle does not lift the refusal.
- R6: An `ev_setup` pulse makes `in_full` 0. An `ev_setup` pulse in the same cycle as `val_cmd` takes priority, and that `val_cmd` is refused.
- R7: `ev_setup` sets both `out_full` and `setup_pend`. `ev_rcvd` sets `out_full` only.
- R8: `out_ovwr` becomes 1 when `ev_setup` arrives while `out_full` is 1 and `clr_cmd` is 0.
- R9: `clr_cmd` clears `out_full`, `setup_pend` and `out_ovwr`. When `clr_cmd` and `ev_setup` coincide, the SETUP is recorded: `out_full` and `setup_pend` end at 1 and `out_ovwr` ends at 0.
- R10: `val_rej` is 1 for exactly the one cycle after each refused `val_cmd`, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| val_cmd | input | 1 | Validate (arm) the IN buffer |
| clr_cmd | input | 1 | Release the OUT buffer |
| ev_sent | input | 1 | IN packet sent on the bus |
| ev_rcvd | input | 1 | OUT data packet received |
| ev_setup | input | 1 | SETUP packet received |
| in_full | output | 1 | IN buffer armed and not yet sent |
| out_full | output | 1 | OUT buffer holds a packet |
| out_ovwr | output | 1 | SETUP overwrote an unreleased packet |
| setup_pend | output | 1 | OUT buffer holds an unread SETUP |
| val_rej | output | 1 | A validate command was refused |

## Verification
A single walked sequence exercises four situations:
- Validate with a free OUT side, which separates acceptance from refusal.
- Validate while an unread SETUP or an overwritten packet is held, which shows the refusal and the unchanged IN flag.
- Validate together with a sent event or with a SETUP, which shows which event wins in each collision.
- Clear together with a SETUP, which shows that the OUT side does not report an overwrite for a buffer released in the same cycle.

A mid-run reset with all flags set shows that every flag returns to zero.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
   // Events reported by the serial interface engine, one cycle each.
   typedef struct packed {
      logic sent;
      logic rcvd;
      logic setup;
   } sie_ev_t;

   // Flags of the receive side, as seen by the transmit side.
   typedef struct packed {
      logic full;
      logic ovwr;
      logic pend;
   } out_flags_t;
endpackage

// File: rtl/ctl_ep_out_track.sv
module ctl_ep_out_track
   import ctl_ep_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       clr_i,
   input  sie_ev_t    ev_i,
   output out_flags_t flags_o
);
   logic full_q, ovwr_q, pend_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
         ovwr_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         // Clear applies first; an arriving packet is recorded after it.
         if (ev_i.setup || ev_i.rcvd) full_q <= 1'b1;
         else if (clr_i)             full_q <= 1'b0;

         if (ev_i.setup)  pend_q <= 1'b1;
         else if (clr_i)  pend_q <= 1'b0;

         if (ev_i.setup && full_q && !clr_i) ovwr_q <= 1'b1;
         else if (clr_i)                     ovwr_q <= 1'b0;
      end
   end

   assign flags_o = '{full: full_q, ovwr: ovwr_q, pend: pend_q};

   p_setup_sets_r7: assert property (@(posedge clk) disable iff (rst)
      ev_i.setup |=> (full_q && pend_q));
   p_overwrite_r8: assert property (@(posedge clk) disable iff (rst)
      (ev_i.setup && full_q && !clr_i) |=> ovwr_q);
   p_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !ev_i.setup && !ev_i.rcvd) |=> (!full_q && !pend_q && !ovwr_q));
   p_clear_setup_r9: assert property (@(posedge clk) disable iff (rst)
      (clr_i && ev_i.setup) |=> (full_q && pend_q && !ovwr_q));
endmodule

// File: rtl/ctl_ep_in_track.sv
module ctl_ep_in_track
   import ctl_ep_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       val_i,
   input  sie_ev_t    ev_i,
   input  out_flags_t out_i,
   output logic       full_o,
   output logic       rej_o
);
   logic blocked, accept;
   logic full_q, rej_q;

   // Refusal uses registered OUT flags plus a SETUP arriving now.
   assign blocked = out_i.ovwr | out_i.pend | ev_i.setup;
   assign accept  = val_i & ~blocked;

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
         rej_q  <= 1'b0;
      end else begin
         rej_q <= val_i & blocked;
         if (ev_i.setup)    full_q <= 1'b0;
         else if (accept)   full_q <= 1'b1;
         else if (ev_i.sent) full_q <= 1'b0;
      end
   end

   assign full_o = full_q;
   assign rej_o  = rej_q;

   p_validate_r2: assert property (@(posedge clk) disable iff (rst)
      (val_i && !out_i.ovwr && !out_i.pend && !ev_i.setup) |=> full_q);
   p_sent_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (ev_i.sent && !val_i && !ev_i.setup) |=> !full_q);
   p_ovwr_blocks_r4: assert property (@(posedge clk) disable iff (rst)
      (val_i && out_i.ovwr && !ev_i.setup && !ev_i.sent) |=> $stable(full_q));
   p_pend_blocks_r5: assert property (@(posedge clk) disable iff (rst)
      (val_i && out_i.pend && !ev_i.setup && !ev_i.sent) |=> $stable(full_q));
   p_setup_cancels_r6: assert property (@(posedge clk) disable iff (rst)
      ev_i.setup |=> !full_q);
   p_rej_cause_r10: assert property (@(posedge clk) disable iff (rst)
      rej_q |-> $past(val_i));
endmodule

// File: rtl/ctl_ep_bufstat.sv
module ctl_ep_bufstat
   import ctl_ep_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic val_cmd,
   input  logic clr_cmd,
   input  logic ev_sent,
   input  logic ev_rcvd,
   input  logic ev_setup,
   output logic in_full,
   output logic out_full,
   output logic out_ovwr,
   output logic setup_pend,
   output logic val_rej
);
   sie_ev_t    ev;
   out_flags_t oflags;

   assign ev = '{sent: ev_sent, rcvd: ev_rcvd, setup: ev_setup};

   ctl_ep_out_track u_out (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (clr_cmd),
      .ev_i    (ev),
      .flags_o (oflags)
   );

   ctl_ep_in_track u_in (
      .clk    (clk),
      .rst    (rst),
      .val_i  (val_cmd),
      .ev_i   (ev),
      .out_i  (oflags),
      .full_o (in_full),
      .rej_o  (val_rej)
   );

   assign out_full   = oflags.full;
   assign out_ovwr   = oflags.ovwr;
   assign setup_pend = oflags.pend;

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (!in_full && !out_full && !out_ovwr && !setup_pend && !val_rej));
endmodule

// File: tb/ctl_ep_bufstat_bench.sv
module ctl_ep_bufstat_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic val_cmd = 0, clr_cmd = 0, ev_sent = 0, ev_rcvd = 0, ev_setup = 0;
   logic in_full, out_full, out_ovwr, setup_pend, val_rej;
   int   n_run = 0, n_fail = 0;
   bit   done = 0;

   always #4 clk = ~clk;   // 125 MHz

   ctl_ep_bufstat u_ctl_ep_bufstat (.*);

   // Vector bits: [9]val [8]clr [7]sent [6]rcvd [5]setup |
   //              [4]in_full [3]out_full [2]out_ovwr [1]setup_pend [0]val_rej
   localparam int NV = 19;
   localparam logic [9:0] VEC [NV] = '{
      10'b10000_10000, // R2 accept on idle
      10'b00100_00000, // R3 sent frees IN
      10'b00010_01000, // R7 data packet sets out_full only
      10'b10000_11000, // R2 accept with data held
      10'b00001_01110, // R6 R8 SETUP cancels IN, overwrites held packet
      10'b10000_01111, // R4 refused while overwritten
      10'b01000_00000, // R9 clear releases all
      10'b00001_01010, // R7 SETUP sets full and pending
      10'b10000_01011, // R5 refused while SETUP pending
      10'b00000_01010, // R10 pulse lasts one cycle
      10'b11000_00001, // R5 clear in same cycle does not lift refusal
      10'b10000_10000, // R2 accept after release
      10'b10100_10000, // R3 validate wins over sent
      10'b10001_01011, // R6 SETUP beats validate
      10'b01001_01010, // R9 clear with SETUP: no overwrite
      10'b01000_00000, // R9 clear
      10'b00010_01000, // R7 data packet
      10'b00001_01110, // R8 SETUP over held data
      10'b01000_00000  // R9 clear
   };

   task automatic check(input logic [4:0] exp, input string req);
      logic [4:0] act;
      act = {in_full, out_full, out_ovwr, setup_pend, val_rej};
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: flags act=%b exp=%b", req, act, exp);
      end
   endtask

   task automatic step(input logic [4:0] stim);
      {val_cmd, clr_cmd, ev_sent, ev_rcvd, ev_setup} = stim;
      @(posedge clk);
      @(negedge clk);
      {val_cmd, clr_cmd, ev_sent, ev_rcvd, ev_setup} = '0;
   endtask

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(5'b00000, "R1 reset");
      rst = 1'b0;
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][9:5]);
         check(VEC[i][4:0], $sformatf("vector %0d", i));
      end
      // R1: build full state then reset mid-run
      step(5'b00010);
      step(5'b00001);
      step(5'b10000);
      check(5'b01111, "R4 setup state before reset");
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      check(5'b00000, "R1 mid-run reset");
      rst = 1'b0;
      // R10: idle cycle after refusal has no pulse
      step(5'b00000);
      check(5'b00000, "R10 idle no pulse");
      // R3: sent with empty buffer keeps it empty
      step(5'b00100);
      check(5'b00000, "R3 sent on empty");
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: act=timeout exp=done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule